// File: doc/BRIEF.md
# Command Mailbox Register File (Device Side)

This block is the device-side register file of a command mailbox. A host reaches it through a plain word-addressed write port and a combinational read port. The host places an opcode, an input length and any input payload words in the mailbox, then sets a doorbell bit. The block passes the command to a local executor through a start pulse. When the executor reports completion, the block latches the return code and the output length and drops the doorbell. From that point the command, status and payload contents stay frozen until the host submits again.

Some commands take a long time. The executor can flag such a command as running in the background when it completes the doorbell phase. A separate background status word then shows which opcode is running and how far it has progressed, as a percentage. When progress reaches 100 the block latches a deferred return code. If the host has enabled it, the block also raises a one-cycle completion interrupt.

Register word addresses (payload selected by the top address bit): 0 capabilities, 1 control, 2 opcode, 3 length, 4 status, 5 background progress, 6 background return code.

Top module: `mbox_regfile`

## Requirements
- R1: Writing the control word (address 1) with bit 0 set while the doorbell is clear sets the doorbell. The busy output and the read of control bit 0 both show it. In the cycle after the write, exe_start pulses high for exactly one cycle, with exe_opcode and exe_in_len showing the opcode word (address 2, bits 15:0) and the length word (address 3, bits 20:0).
- R2: exe_done while the doorbell is set clears the doorbell on the next edge. It stores exe_rc in the status word (address 4, bits 15:0) and exe_out_len in the length word.
- R3: While the doorbell is clear, the executor cannot change the status word or any payload word: exe_done and executor payload writes have no effect.
- R4: While the doorbell is set, host writes to the opcode word, the length word and the payload are ignored, and a second ring starts no new command.
- R5: Before ringing, the host may write the payload and the command words in either order. Each reads back what was written, and payload word i written by the host is seen by the executor at index i.
- R6: The capabilities word (address 0) reads the payload size exponent in bits 4:0, the background-interrupt capability in bit 5 and the interrupt message number in bits 9:6.
- R7: A completion with exe_bg set copies the opcode into background progress bits 15:0 and sets its percent field (bits 22:16) to 0. Later progress inputs update the percent field, with any value above 100 held at 100. On reaching 100, exe_bg_rc is latched into the background return-code word (address 6, bits 15:0). Progress inputs are ignored while percent equals 100.
- R8: When the percent field reaches 100 and control bit 1 (interrupt enable) is set, mbox_irq is high for exactly the following cycle. With the enable clear, mbox_irq stays low.
- R9: After reset the doorbell, interrupt enable, mbox_irq, status, opcode, length and background return code are zero, and the percent field reads 100.
- R10: The length field is 21 bits wide. Bits 31:21 of the length word always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host word address; top bit selects payload |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| busy | output | 1 | Doorbell state |
| mbox_irq | output | 1 | Background completion interrupt pulse |
| exe_start | output | 1 | Command start pulse to executor |
| exe_opcode | output | 16 | Opcode of current command |
| exe_in_len | output | 21 | Input payload length |
| exe_done | input | 1 | Executor completion pulse |
| exe_rc | input | 16 | Return code with completion |
| exe_out_len | input | 21 | Output payload length with completion |
| exe_bg | input | 1 | Completion continues in background |
| exe_prog_vld | input | 1 | Background progress update strobe |
| exe_prog_pct | input | 7 | Background percent complete |
| exe_bg_rc | input | 16 | Final background return code |
| exe_pl_we | input | 1 | Executor payload write strobe |
| exe_pl_idx | input | IDX_W | Executor payload word index |
| exe_pl_wdata | input | 32 | Executor payload write data |
| exe_pl_rdata | output | 32 | Payload word at exe_pl_idx |

## Verification
The bench builds the block with the smallest legal payload exponent, 8, which gives 64 words. That size lets it write and read the last payload index and check that the executor sees the same word. Background-interrupt capability is on and the message number is 5, so every capability field is non-zero and shows in its own bit position. With the capability present, the tests separate the effect of the enable bit itself: irq with enable set, silence with it clear. Progress values above 100 check the clamp and the latching of the deferred return code.

// File: rtl/mbox_regfile.sv
module mbox_regfile #(
  parameter int PAY_EXP    = 8,
  parameter bit BG_IRQ_CAP = 1'b1,
  parameter int IRQ_MSG    = 0,
  localparam int IDX_W  = PAY_EXP - 2,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              busy,
  output logic              mbox_irq,
  output logic              exe_start,
  output logic [15:0]       exe_opcode,
  output logic [20:0]       exe_in_len,
  input  logic              exe_done,
  input  logic [15:0]       exe_rc,
  input  logic [20:0]       exe_out_len,
  input  logic              exe_bg,
  input  logic              exe_prog_vld,
  input  logic [6:0]        exe_prog_pct,
  input  logic [15:0]       exe_bg_rc,
  input  logic              exe_pl_we,
  input  logic [IDX_W-1:0]  exe_pl_idx,
  input  logic [31:0]       exe_pl_wdata,
  output logic [31:0]       exe_pl_rdata
);
  localparam int PAY_WORDS = 1 << IDX_W;
  localparam logic [ADDR_W-2:0] R_CAPS = 0, R_CTRL = 1, R_OP = 2, R_LEN = 3,
                                R_STAT = 4, R_BGP = 5, R_BGRC = 6;
  localparam logic [6:0] PCT_FULL = 7'd100;

  logic        db_q, irq_en_q, irq_q, start_q;
  logic [15:0] op_q, status_q, bg_op_q, bg_rc_q;
  logic [20:0] len_q;
  logic [6:0]  bg_pct_q;
  logic [31:0] pl_mem [PAY_WORDS];

  wire              is_pl    = host_addr[ADDR_W-1];
  wire [ADDR_W-2:0] rsel     = host_addr[ADDR_W-2:0];
  wire [IDX_W-1:0]  host_idx = host_addr[IDX_W-1:0];
  wire wr_reg    = host_we && !is_pl;
  wire wr_ctrl   = wr_reg && rsel == R_CTRL;
  wire ring      = wr_ctrl && host_wdata[0] && !db_q;
  wire fin       = db_q && exe_done;
  wire prog_take = exe_prog_vld && bg_pct_q != PCT_FULL;
  wire [6:0] pct_new = (exe_prog_pct > PCT_FULL) ? PCT_FULL : exe_prog_pct;

  assign busy       = db_q;
  assign mbox_irq   = irq_q;
  assign exe_start  = start_q;
  assign exe_opcode = op_q;
  assign exe_in_len = len_q;
  assign exe_pl_rdata = pl_mem[exe_pl_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q     <= 1'b0;
      irq_en_q <= 1'b0;
      irq_q    <= 1'b0;
      start_q  <= 1'b0;
      op_q     <= '0;
      len_q    <= '0;
      status_q <= '0;
      bg_op_q  <= '0;
      bg_rc_q  <= '0;
      bg_pct_q <= PCT_FULL;
    end else begin
      start_q <= ring;
      irq_q   <= 1'b0;
      if (wr_ctrl) irq_en_q <= host_wdata[1] & BG_IRQ_CAP;
      if (ring) db_q <= 1'b1;
      else if (fin) db_q <= 1'b0;
      if (wr_reg && !db_q && rsel == R_OP)  op_q  <= host_wdata[15:0];
      if (wr_reg && !db_q && rsel == R_LEN) len_q <= host_wdata[20:0];
      if (fin) begin
        status_q <= exe_rc;
        len_q    <= exe_out_len;
        if (exe_bg) begin
          bg_op_q  <= op_q;
          bg_pct_q <= '0;
        end
      end else if (prog_take) begin
        bg_pct_q <= pct_new;
        if (pct_new == PCT_FULL) begin
          bg_rc_q <= exe_bg_rc;
          irq_q   <= irq_en_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!db_q && host_we && is_pl) pl_mem[host_idx] <= host_wdata;
    else if (db_q && exe_pl_we)    pl_mem[exe_pl_idx] <= exe_pl_wdata;
  end

  always_comb begin
    host_rdata = '0;
    if (is_pl) host_rdata = pl_mem[host_idx];
    else begin
      case (rsel)
        R_CAPS: host_rdata = {22'd0, 4'(IRQ_MSG), BG_IRQ_CAP, 5'(PAY_EXP)};
        R_CTRL: host_rdata = {30'd0, irq_en_q, db_q};
        R_OP:   host_rdata = {16'd0, op_q};
        R_LEN:  host_rdata = {11'd0, len_q};
        R_STAT: host_rdata = {16'd0, status_q};
        R_BGP:  host_rdata = {9'd0, bg_pct_q, bg_op_q};
        R_BGRC: host_rdata = {16'd0, bg_rc_q};
        default: host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbox_regfile_chk.sv
module mbox_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        exe_start,
  input logic        exe_done,
  input logic        mbox_irq,
  input logic        irq_en_q,
  input logic [15:0] status_q,
  input logic [6:0]  bg_pct_q
);
  AST_START_ON_RING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> exe_start); // R1
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && exe_done |=> !busy); // R2
  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) |-> $stable(status_q)); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    exe_start |-> !$past(busy)); // R4
  AST_PCT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bg_pct_q <= 7'd100); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_irq |-> $past(irq_en_q) && bg_pct_q == 7'd100); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_irq |=> !mbox_irq); // R8
endmodule

bind mbox_regfile mbox_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .exe_start(exe_start),
  .exe_done(exe_done), .mbox_irq(mbox_irq), .irq_en_q(irq_en_q),
  .status_q(status_q), .bg_pct_q(bg_pct_q)
);

// File: tb/mbox_regfile_bench.sv
module mbox_regfile_bench;
  localparam int PAY_EXP = 8;
  localparam int IDX_W = PAY_EXP - 2;
  localparam int ADDR_W = IDX_W + 1;
  localparam logic [ADDR_W-1:0] A_CAPS = 0, A_CTRL = 1, A_OP = 2, A_LEN = 3,
                                A_STAT = 4, A_BGP = 5, A_BGRC = 6;

  logic clk = 0, rst_n = 0;
  logic host_we = 0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic busy, mbox_irq, exe_start;
  logic [15:0] exe_opcode;
  logic [20:0] exe_in_len;
  logic exe_done = 0, exe_bg = 0, exe_prog_vld = 0, exe_pl_we = 0;
  logic [15:0] exe_rc = '0, exe_bg_rc = '0;
  logic [20:0] exe_out_len = '0;
  logic [6:0] exe_prog_pct = '0;
  logic [IDX_W-1:0] exe_pl_idx = '0;
  logic [31:0] exe_pl_wdata = '0, exe_pl_rdata;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  mbox_regfile #(.PAY_EXP(PAY_EXP), .BG_IRQ_CAP(1'b1), .IRQ_MSG(5)) u_mbox_regfile (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .mbox_irq(mbox_irq), .exe_start(exe_start), .exe_opcode(exe_opcode),
    .exe_in_len(exe_in_len), .exe_done(exe_done), .exe_rc(exe_rc),
    .exe_out_len(exe_out_len), .exe_bg(exe_bg), .exe_prog_vld(exe_prog_vld),
    .exe_prog_pct(exe_prog_pct), .exe_bg_rc(exe_bg_rc), .exe_pl_we(exe_pl_we),
    .exe_pl_idx(exe_pl_idx), .exe_pl_wdata(exe_pl_wdata), .exe_pl_rdata(exe_pl_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] pl(input int i);
    return {1'b1, IDX_W'(i)};
  endfunction

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic finish_cmd(input logic [15:0] rc, input logic [20:0] len, input logic bg);
    @(negedge clk); exe_done = 1; exe_rc = rc; exe_out_len = len; exe_bg = bg;
    @(negedge clk); exe_done = 0; exe_bg = 0;
  endtask

  task automatic progress(input logic [6:0] p, input logic [15:0] brc);
    @(negedge clk); exe_prog_vld = 1; exe_prog_pct = p; exe_bg_rc = brc;
    @(negedge clk); exe_prog_vld = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R9 busy", busy, 0);
    chk("R9 irq", mbox_irq, 0);
    rd(A_CTRL, d); chk("R9 ctrl", d, 0);
    rd(A_STAT, d); chk("R9 status", d, 0);
    rd(A_LEN, d);  chk("R9 length", d, 0);
    rd(A_BGP, d);  chk("R9 bg progress", d, 32'h0064_0000);
    rd(A_BGRC, d); chk("R9 bg rc", d, 0);
    rd(A_CAPS, d); chk("R6 caps", d, 32'h0000_0168);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    wr(pl(0), 32'hA5A5_0001);
    wr(A_OP, 32'hFFFF_1234);
    wr(A_LEN, 32'd8);
    wr(A_CTRL, 32'h1);
    chk("R1 start pulse", exe_start, 1);
    chk("R1 opcode", exe_opcode, 32'h1234);
    chk("R1 in len", exe_in_len, 8);
    chk("R1 busy", busy, 1);
    rd(A_CTRL, d); chk("R1 ctrl db bit", d, 1);
    exe_pl_idx = 0; #1; chk("R5 exe sees payload", exe_pl_rdata, 32'hA5A5_0001);
    @(negedge clk); chk("R1 start one cycle", exe_start, 0);
    exe_pl_we = 1; exe_pl_idx = IDX_W'(63); exe_pl_wdata = 32'hBEEF_0063;
    @(negedge clk); exe_pl_we = 0;
    finish_cmd(16'h0000, 21'h1ABCDE, 0);
    chk("R2 busy cleared", busy, 0);
    rd(A_STAT, d); chk("R2 status", d, 0);
    rd(A_LEN, d);  chk("R2 out len", d, 32'h1A_BCDE);
    rd(pl(63), d); chk("R2 out payload", d, 32'hBEEF_0063);
  endtask

  task automatic t_order;
    logic [31:0] d;
    wr(A_LEN, 32'hFFFF_FFFF);
    rd(A_LEN, d); chk("R10 len mask", d, 32'h001F_FFFF);
    wr(A_OP, 32'h0042);
    wr(pl(5), 32'h1111_2222);
    rd(A_OP, d);  chk("R5 op readback", d, 32'h42);
    rd(pl(5), d); chk("R5 payload readback", d, 32'h1111_2222);
    exe_pl_idx = 5; #1; chk("R5 exe index", exe_pl_rdata, 32'h1111_2222);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d;
    wr(A_CTRL, 32'h1);
    chk("R1 start again", exe_start, 1);
    wr(A_OP, 32'h0777);
    wr(A_LEN, 32'h33);
    wr(pl(5), 32'hDEAD_DEAD);
    @(negedge clk); host_we = 1; host_addr = A_CTRL; host_wdata = 32'h1;
    @(negedge clk); host_we = 0;
    chk("R4 no restart", exe_start, 0);
    rd(A_OP, d);  chk("R4 op ignored", d, 32'h42);
    rd(A_LEN, d); chk("R4 len ignored", d, 32'h1F_FFFF);
    rd(pl(5), d); chk("R4 payload ignored", d, 32'h1111_2222);
    chk("R4 still busy", busy, 1);
    finish_cmd(16'h0005, 21'd4, 0);
    rd(A_STAT, d); chk("R2 error rc", d, 32'h5);
  endtask

  task automatic t_frozen;
    logic [31:0] d;
    @(negedge clk); exe_pl_we = 1; exe_pl_idx = 5; exe_pl_wdata = 32'h0BAD_0BAD;
    @(negedge clk); exe_pl_we = 0;
    finish_cmd(16'h00EE, 21'd99, 1);
    rd(pl(5), d);  chk("R3 payload frozen", d, 32'h1111_2222);
    rd(A_STAT, d); chk("R3 status frozen", d, 32'h5);
    rd(A_LEN, d);  chk("R3 len frozen", d, 32'd4);
    rd(A_BGP, d);  chk("R3 bg untouched", d, 32'h0064_0000);
    chk("R3 busy stays clear", busy, 0);
  endtask

  task automatic t_bg_irq;
    logic [31:0] d;
    wr(A_OP, 32'h4400);
    wr(A_CTRL, 32'h3);
    finish_cmd(16'h0001, 21'd0, 1);
    rd(A_BGP, d); chk("R7 bg start", d, 32'h0000_4400);
    progress(7'd40, 16'h0009);
    rd(A_BGP, d); chk("R7 pct 40", d, 32'h0028_4400);
    chk("R8 no irq at 40", mbox_irq, 0);
    rd(A_BGRC, d); chk("R7 rc not yet", d, 0);
    @(negedge clk); exe_prog_vld = 1; exe_prog_pct = 7'd120; exe_bg_rc = 16'h0007;
    @(negedge clk); exe_prog_vld = 0;
    chk("R8 irq pulse", mbox_irq, 1);
    rd(A_BGP, d); chk("R7 pct clamp", d, 32'h0064_4400);
    rd(A_BGRC, d); chk("R7 bg rc", d, 32'h7);
    @(negedge clk); chk("R8 irq one cycle", mbox_irq, 0);
    progress(7'd10, 16'h0003);
    rd(A_BGP, d); chk("R7 ignored when full", d, 32'h0064_4400);
    chk("R8 no second irq", mbox_irq, 0);
  endtask

  task automatic t_bg_noirq;
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h1);
    finish_cmd(16'h0001, 21'd0, 1);
    progress(7'd100, 16'h0002);
    chk("R8 irq disabled", mbox_irq, 0);
    rd(A_BGRC, d); chk("R7 rc latched", d, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_busy_ignore();
    t_frozen();
    t_bg_irq();
    t_bg_noirq();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule